// File: doc/BRIEF.md
# Variable-Width Bit Packer

This block turns a stream of variable-length codewords into a stream of fixed-width words. Each input beat carries a payload, a length field and an end-of-packet flag. Only the low `in_len` bits of the payload count. The block appends them to an internal accumulator, starting at the lowest unused bit position. As soon as a full output word is available, the block offers it downstream.

A beat that closes a packet forces a flush. Any bits left over are sent as one final word, zero-filled above the valid bits, and that word is marked as the packet end. The same block also passes full-width literal words, for example when no entropy coder sits upstream: those beats simply use `in_len` equal to the payload width.

Both sides use a valid/ready handshake. The output word is taken straight from the accumulator, so a word becomes visible one cycle after the beat that completed it.

Top module: `vlcpack_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Only bits `[in_len-1:0]` of `in_data` enter the stream. Payload bits at or above `in_len` have no effect on any output word.
- R3: Packing is LSB first. Bit j of the k-th output word of a packet is bit number k*OUT_W+j of the packet's bitstream. That bitstream is formed by concatenating, beat after beat, the valid bits of each beat starting from bit 0.
- R4: A word is offered whenever OUT_W or more bits are pending. While `out_valid` is high, `in_ready` is low.
- R5: On a beat with `in_last`=1, the remaining pending bits are sent as one word whose bits above the valid count are 0. `out_last` is 1 on that word and on no other word of the packet. A packet whose bit count is a multiple of OUT_W ends on a full word carrying `out_last`.
- R6: A beat with `in_len`=0 adds no bits. If it carries `in_last` and bits are pending, it triggers the flush of R5. If no bits are pending, it produces no output word.
- R7: Beats with `in_len`=IN_W (full-width literals) are packed like any other beat. Each one yields IN_W/OUT_W consecutive output words when aligned.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | IN_W | Codeword bits, valid in the low `in_len` positions |
| in_len | input | $clog2(IN_W+1) | Number of valid codeword bits, 0 to IN_W |
| in_last | input | 1 | Beat closes the packet |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | OUT_W | Packed word, LSB first |
| out_last | output | 1 | Word holds the final bits of a packet |

## Verification
The assertions assume that `in_len` never exceeds IN_W while `in_valid` is high, and that the consumer may withhold `out_ready` for any length of time. The stimulus draws every length from 0 to IN_W inclusive. It puts random junk above the valid bits, holds a presented beat until it is accepted, and toggles `out_ready` at random rates. Expected words come from rebuilding each packet's bitstream in the bench and slicing it into OUT_W-bit pieces.

// File: rtl/vlcpack_pkg.sv
package vlcpack_pkg;

    // Classification of what the accumulator can currently offer downstream
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_FULL = 2'd1,
        WK_TAIL = 2'd2
    } word_kind_t;

    // Width of a field able to hold values 0..n
    function automatic int count_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/vlcpack_merge.sv
module vlcpack_merge #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 24,
    parameter int LEN_W = 5,
    parameter int CNT_W = 5
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [CNT_W-1:0] fill,
    input  logic [IN_W-1:0]  data,
    input  logic [LEN_W-1:0] len,
    output logic [ACC_W-1:0] merged,
    output logic [CNT_W-1:0] merged_fill
);

    logic [LEN_W-1:0] eff_len;
    logic [IN_W-1:0]  keep_mask;
    logic [ACC_W-1:0] widened;

    always_comb begin
        // Lengths beyond the payload width are clamped to the full width
        eff_len     = (len > LEN_W'(IN_W)) ? LEN_W'(IN_W) : len;
        keep_mask   = ~({IN_W{1'b1}} << eff_len);
        widened     = {{(ACC_W-IN_W){1'b0}}, data & keep_mask};
        merged      = acc | (widened << fill);
        merged_fill = fill + CNT_W'(eff_len);
    end

endmodule

// File: rtl/vlcpack_store.sv
module vlcpack_store
    import vlcpack_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8,
    parameter int ACC_W = 24,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             out_ready,
    input  logic [ACC_W-1:0] merged,
    input  logic [CNT_W-1:0] merged_fill,
    output logic [ACC_W-1:0] acc_q,
    output logic [CNT_W-1:0] fill_q,
    output logic             in_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last
);

    logic       flush_q;
    word_kind_t kind;
    logic       take_in;
    logic       take_out;

    always_comb begin
        if (fill_q >= CNT_W'(OUT_W)) begin
            kind = (flush_q && fill_q == CNT_W'(OUT_W)) ? WK_TAIL : WK_FULL;
        end else if (flush_q && fill_q != '0) begin
            kind = WK_TAIL;
        end else begin
            kind = WK_NONE;
        end
        out_valid = (kind != WK_NONE);
        out_last  = (kind == WK_TAIL);
        out_data  = acc_q[OUT_W-1:0];
        in_ready  = !flush_q && (fill_q < CNT_W'(OUT_W));
        take_in   = in_valid && in_ready;
        take_out  = out_valid && out_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            fill_q  <= '0;
            flush_q <= 1'b0;
        end else if (take_in) begin
            acc_q   <= merged;
            fill_q  <= merged_fill;
            flush_q <= in_last && (merged_fill != '0);
        end else if (take_out) begin
            if (kind == WK_TAIL) begin
                acc_q   <= '0;
                fill_q  <= '0;
                flush_q <= 1'b0;
            end else begin
                acc_q   <= acc_q >> OUT_W;
                fill_q  <= fill_q - CNT_W'(OUT_W);
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready)); // R1

    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
        fill_q <= CNT_W'(IN_W + OUT_W - 1)); // R4

    AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R4

    AST_TAIL_PADDED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last && fill_q < CNT_W'(OUT_W))
            |-> ((out_data & ({OUT_W{1'b1}} << fill_q)) == '0)); // R5

    AST_EMPTY_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (take_in && in_last && merged_fill == '0) |=> !out_valid); // R6

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready)
            |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8

endmodule

// File: rtl/vlcpack_top.sv
module vlcpack_top
    import vlcpack_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8,
    parameter int LEN_W = count_bits(IN_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    input  logic [LEN_W-1:0] in_len,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last
);

    localparam int ACC_W = IN_W + OUT_W;
    localparam int CNT_W = count_bits(ACC_W);

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] fill_q;
    logic [ACC_W-1:0] merged;
    logic [CNT_W-1:0] merged_fill;

    vlcpack_merge #(
        .IN_W (IN_W),
        .ACC_W(ACC_W),
        .LEN_W(LEN_W),
        .CNT_W(CNT_W)
    ) u_merge (
        .acc        (acc_q),
        .fill       (fill_q),
        .data       (in_data),
        .len        (in_len),
        .merged     (merged),
        .merged_fill(merged_fill)
    );

    vlcpack_store #(
        .IN_W (IN_W),
        .OUT_W(OUT_W),
        .ACC_W(ACC_W),
        .CNT_W(CNT_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .out_ready  (out_ready),
        .merged     (merged),
        .merged_fill(merged_fill),
        .acc_q      (acc_q),
        .fill_q     (fill_q),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last)
    );

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (in_len <= LEN_W'(IN_W))); // R2

endmodule

// File: tb/vlcpack_top_test.sv
`timescale 1ns/1ps
module vlcpack_top_test;

    localparam int IN_W  = 16;
    localparam int OUT_W = 8;
    localparam int LEN_W = $clog2(IN_W + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [IN_W-1:0]  in_data = '0;
    logic [LEN_W-1:0] in_len = '0;
    logic             in_last = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [OUT_W-1:0] out_data;
    logic             out_last;

    int checks = 0;
    int errors = 0;

    logic [IN_W-1:0]  b_data [0:1023];
    logic [LEN_W-1:0] b_len  [0:1023];
    logic             b_last [0:1023];
    int               nb = 0;
    logic [OUT_W-1:0] exp_w  [0:4095];
    logic             exp_l  [0:4095];
    int               ne = 0;
    logic             pbits  [0:8191];
    int               np = 0;

    vlcpack_top #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_len(in_len), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Record a beat and extend the expected word list from the packet bitstream
    task automatic add_beat(input logic [IN_W-1:0] d, input int l, input bit last);
        b_data[nb] = d;
        b_len[nb]  = LEN_W'(l);
        b_last[nb] = last;
        nb++;
        for (int i = 0; i < l; i++) begin
            pbits[np] = d[i];
            np++;
        end
        if (last) begin
            for (int k = 0; k < np; k += OUT_W) begin
                logic [OUT_W-1:0] w;
                w = '0;
                for (int j = 0; j < OUT_W; j++)
                    if (k + j < np) w[j] = pbits[k + j];
                exp_w[ne] = w;
                exp_l[ne] = (k + OUT_W >= np);
                ne++;
            end
            np = 0;
        end
    endtask

    task automatic run_seq(input string req, input int in_p, input int out_p);
        int bi = 0;
        int ei = 0;
        int cyc = 0;
        bit hold = 0;
        bit drop = 0;
        logic [OUT_W-1:0] hd = '0;
        logic hl = 1'b0;
        while ((bi < nb || ei < ne) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (drop) begin
                in_valid = 1'b0;
                drop = 0;
            end
            out_ready = (($urandom % 100) < out_p);
            if (!in_valid && bi < nb && (($urandom % 100) < in_p)) begin
                in_valid = 1'b1;
                in_data  = b_data[bi];
                in_len   = b_len[bi];
                in_last  = b_last[bi];
            end
            #1;
            if (hold)
                chk(out_valid && out_data == hd && out_last == hl, "R8",
                    "word held under stall", {out_valid, out_last, out_data}, {1'b1, hl, hd});
            if (out_valid)
                chk(!in_ready, "R4", "in_ready while word waits", in_ready, 0);
            if (in_valid && in_ready) begin
                bi++;
                drop = 1;
            end
            if (out_valid && out_ready) begin
                if (ei < ne)
                    chk(out_data == exp_w[ei] && out_last == exp_l[ei], req,
                        $sformatf("word %0d {last,data}", ei),
                        {out_last, out_data}, {exp_l[ei], exp_w[ei]});
                else
                    chk(0, req, "unexpected extra word", {out_last, out_data}, 0);
                ei++;
            end
            hold = out_valid && !out_ready;
            hd = out_data;
            hl = out_last;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        #1;
        chk(bi == nb && ei == ne, req, "all beats and words transferred", ei, ne);
        chk(!out_valid, req, "idle after sequence", out_valid, 0);
        nb = 0;
        ne = 0;
        np = 0;
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        // R7: full-width literal beats
        add_beat(16'hA55A, IN_W, 0);
        add_beat(16'h1234, IN_W, 0);
        add_beat(16'hBEEF, IN_W, 1);
        run_seq("R7", 100, 100);

        // R5: partial, exact and spill-over flushes (05 | C3 | FF,01)
        add_beat(16'h0005, 3, 1);
        add_beat(16'h00C3, 8, 1);
        add_beat(16'h01FF, 9, 1);
        run_seq("R5", 100, 100);

        // R2: junk above the valid bits; expected single word DA
        add_beat(16'hFFFE, 1, 0);
        add_beat(16'hFFF5, 3, 0);
        add_beat(16'hABCD, 4, 1);
        run_seq("R2", 80, 80);

        // R6: zero-length beats, flush with pending bits, empty close
        add_beat(16'h0013, 5, 0);
        add_beat(16'hFFFF, 0, 0);
        add_beat(16'hFFFF, 0, 1);
        add_beat(16'h7777, 0, 1);
        add_beat(16'h0001, 1, 1);
        run_seq("R6", 100, 50);

        // R3: random codewords with random stalls on both sides
        for (int i = 0; i < 400; i++)
            add_beat(IN_W'($urandom), int'($urandom % (IN_W + 1)),
                     (i == 399) || (($urandom % 8) == 0));
        run_seq("R3", 70, 60);

        // R8: heavy output backpressure
        for (int i = 0; i < 150; i++)
            add_beat(IN_W'($urandom), int'($urandom % (IN_W + 1)),
                     (i == 149) || (($urandom % 6) == 0));
        run_seq("R8", 90, 25);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule